// File: doc/BRIEF.md
# Dual-Bank Port-Mapped GPIO Controller

This block gives a host a byte-wide, port-mapped view of a set of general-purpose pins. The pins are split at a parameterised index into a core bank and a resume bank. Each bank carries three per-pin control sets: an enable that lets the pin be used, a direction that selects input or output, and a level that holds the value driven out or reports the value seen at the pad. Each register byte covers eight pins. The resume bank repeats the core bank's layout 0x20 bytes higher, and its pins are numbered again from zero.

The host issues single-cycle read or write strobes with an 8-bit offset. Read data comes back from a register one cycle after the strobe. A pin drives only when it is enabled and set as an output. A level write does not touch pins set as inputs, so software cannot preset an output value before it turns the pin into an output. Input values pass through a two-flop synchroniser before they can be read.

Top module: `dual_bank_gpio`

## Requirements
- R1: After reset, enable bits are 1 for the lowest CORE_EN_CNT core pins and the lowest RESUME_EN_CNT resume pins and 0 for all others. Every direction bit is 1, every stored level bit is 0, and pin_oe, pin_out and bus_rdata are all zero. With the defaults (14 pins, resume bank from pin 10, counts 7 and 3), offset 0x00 reads 0x7F and offset 0x20 reads 0x07.
- R2: Bank base offsets are 0x00 for the core bank and 0x20 for the resume bank. Within a bank, enable is at +0x00, direction at +0x04 and level at +0x08. A pin with local index k (global index minus RESUME_START for resume pins) sits in byte base+reg+k/8, at bit k%8.
- R3: A direction bit of 1 makes the pin an input and 0 makes it an output. pin_oe[i] is 1 exactly when the pin's enable bit is 1 and its direction bit is 0. A register write changes pin_oe in the cycle after the write strobe.
- R4: pin_out[i] equals the pin's stored level bit. A level write to an output pin changes pin_out in the cycle after the strobe.
- R5: A level write leaves the stored level bit of every pin whose direction bit is 1 at the time of the write unchanged. This is visible on pin_out after that pin is turned into an output.
- R6: A level read returns the stored level bit for output pins. For input pins it returns pin_in after a two-flop synchroniser, so a pin change that is present at clock edge k is first returned by a read whose strobe is sampled at edge k+2.
- R7: bus_rdata is loaded on every clock edge. It takes the addressed byte if bus_rd was high and is 0 otherwise. A write in the same cycle as a read does not affect that read's data.
- R8: Bits of pins beyond a bank's pin count read 0 and ignore writes. Reads return 0 from offsets with bit 7 or bit 6 set, from in-bank offsets 0x0C to 0x1F, and from byte indices beyond the bank's byte count. Writes to those offsets change nothing.
- R9: Enable bits of every implemented pin can be written and read back, including pins that are disabled after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, registered |
| pin_in | input | NUM_PINS | Raw pin input values |
| pin_out | output | NUM_PINS | Per-pin output value |
| pin_oe | output | NUM_PINS | Per-pin output enable |

## Verification
Register writes show up on pin_out and pin_oe one cycle after the strobe, and read data shows up one cycle after the read strobe. The bench drives inputs on the falling edge, updates its behavioural model on the rising edge from the same inputs, and compares all outputs on every following falling edge. Input-pin level reads lag pin_in by the two synchroniser stages. The model keeps its own two-stage history of pin_in, so a read issued right after a pin change is checked against the older value. Directed reads are sampled on the falling edge after their strobe edge.

// File: rtl/gdb_pkg.sv
package gdb_pkg;
   localparam logic [7:0] CORE_BASE   = 8'h00;
   localparam logic [7:0] RESUME_BASE = 8'h20;
   localparam int         BANK_MAX_PINS = 32;
   localparam int         BANK_BYTES_MAX = BANK_MAX_PINS / 8;

   typedef enum logic [1:0] {
      RK_ENABLE = 2'd0,
      RK_DIR    = 2'd1,
      RK_LEVEL  = 2'd2,
      RK_NONE   = 2'd3
   } reg_kind_e;

   typedef struct packed {
      logic      hit;
      logic      bank;
      reg_kind_e kind;
      logic [1:0] byte_idx;
   } dec_t;
endpackage

// File: rtl/gdb_decode.sv
module gdb_decode #(
   parameter int CORE_BYTES = 2,
   parameter int RES_BYTES  = 1
) (
   input  logic [7:0]   addr,
   output gdb_pkg::dec_t dec
);
   import gdb_pkg::*;

   if (CORE_BYTES < 1 || CORE_BYTES > BANK_BYTES_MAX) begin : g_bad_core
      $error("gdb_decode: CORE_BYTES out of range");
   end
   if (RES_BYTES < 1 || RES_BYTES > BANK_BYTES_MAX) begin : g_bad_res
      $error("gdb_decode: RES_BYTES out of range");
   end

   logic [4:0] rel;
   logic       in_window;
   logic [2:0] bank_bytes;
   reg_kind_e  kind_w;

   always_comb begin
      rel       = addr[4:0];
      in_window = (addr[7:6] == 2'b00);
      unique case (rel[4:2])
         3'd0:    kind_w = RK_ENABLE;
         3'd1:    kind_w = RK_DIR;
         3'd2:    kind_w = RK_LEVEL;
         default: kind_w = RK_NONE;
      endcase
      bank_bytes   = addr[5] ? 3'(RES_BYTES) : 3'(CORE_BYTES);
      dec.bank     = addr[5];
      dec.kind     = kind_w;
      dec.byte_idx = rel[1:0];
      dec.hit      = in_window && (kind_w != RK_NONE) &&
                     ({1'b0, rel[1:0]} < bank_bytes);
   end
endmodule

// File: rtl/gdb_sync.sv
module gdb_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gdb_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("gdb_sync: W must be positive");
   end

   logic [W-1:0] stage [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage[s] <= '0;
         end else begin
            stage[s] <= (s == 0) ? d : stage[(s == 0) ? 0 : s - 1];
         end
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/gdb_bank.sv
module gdb_bank #(
   parameter int NPIN        = 10,
   parameter int EN_CNT      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  gdb_pkg::reg_kind_e kind,
   input  logic [1:0]        byte_idx,
   input  logic [7:0]        wdata,
   input  logic [NPIN-1:0]   pin_in,
   output logic [7:0]        rd_byte,
   output logic [NPIN-1:0]   en_q,
   output logic [NPIN-1:0]   dir_q,
   output logic [NPIN-1:0]   lvl_q
);
   import gdb_pkg::*;

   localparam int NBYTE = (NPIN + 7) / 8;

   if (NPIN < 1 || NPIN > BANK_MAX_PINS) begin : g_bad_npin
      $error("gdb_bank: NPIN out of range");
   end
   if (EN_CNT < 0 || EN_CNT > NPIN) begin : g_bad_en
      $error("gdb_bank: EN_CNT out of range");
   end

   logic [NPIN-1:0] sync_q;
   logic [NPIN-1:0] lvl_view;

   gdb_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (sync_q)
   );

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      localparam int BY = i / 8;
      localparam int BI = i % 8;
      localparam logic EN_RST = (i < EN_CNT);
      logic sel;
      logic en_r, dir_r, lvl_r;

      assign sel = wr_en && (byte_idx == 2'(BY));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_r  <= EN_RST;
            dir_r <= 1'b1;
            lvl_r <= 1'b0;
         end else if (sel) begin
            case (kind)
               RK_ENABLE: en_r  <= wdata[BI];
               RK_DIR:    dir_r <= wdata[BI];
               RK_LEVEL:  if (!dir_r) lvl_r <= wdata[BI];
               default:   ;
            endcase
         end
      end

      assign en_q[i]     = en_r;
      assign dir_q[i]    = dir_r;
      assign lvl_q[i]    = lvl_r;
      assign lvl_view[i] = dir_r ? sync_q[i] : lvl_r;
   end

   logic [BANK_MAX_PINS-1:0] en_pad, dir_pad, lvl_pad;
   logic [4:0]               sh;

   always_comb begin
      en_pad  = BANK_MAX_PINS'(en_q);
      dir_pad = BANK_MAX_PINS'(dir_q);
      lvl_pad = BANK_MAX_PINS'(lvl_view);
      sh      = {byte_idx, 3'b000};
      rd_byte = 8'h00;
      if (int'(byte_idx) < NBYTE) begin
         case (kind)
            RK_ENABLE: rd_byte = 8'(en_pad  >> sh);
            RK_DIR:    rd_byte = 8'(dir_pad >> sh);
            RK_LEVEL:  rd_byte = 8'(lvl_pad >> sh);
            default:   rd_byte = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/dual_bank_gpio.sv
module dual_bank_gpio #(
   parameter int NUM_PINS      = 14,
   parameter int RESUME_START  = 10,
   parameter int CORE_EN_CNT   = 7,
   parameter int RESUME_EN_CNT = 3,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [7:0]          bus_addr,
   input  logic [7:0]          bus_wdata,
   input  logic                bus_wr,
   input  logic                bus_rd,
   output logic [7:0]          bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe
);
   import gdb_pkg::*;

   localparam int CORE_PINS  = RESUME_START;
   localparam int RES_PINS   = NUM_PINS - RESUME_START;
   localparam int CORE_BYTES = (CORE_PINS + 7) / 8;
   localparam int RES_BYTES  = (RES_PINS + 7) / 8;

   if (RESUME_START < 1 || RESUME_START >= NUM_PINS) begin : g_bad_split
      $error("dual_bank_gpio: RESUME_START must split the pins into two banks");
   end

   dec_t dec;
   logic wr_core, wr_res;
   logic [7:0] rd_core, rd_res;
   logic [NUM_PINS-1:0] en_all, dir_all, lvl_all;

   gdb_decode #(.CORE_BYTES(CORE_BYTES), .RES_BYTES(RES_BYTES)) u_dec (
      .addr (bus_addr),
      .dec  (dec)
   );

   assign wr_core = bus_wr && dec.hit && !dec.bank;
   assign wr_res  = bus_wr && dec.hit &&  dec.bank;

   gdb_bank #(.NPIN(CORE_PINS), .EN_CNT(CORE_EN_CNT), .SYNC_STAGES(SYNC_STAGES)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_core),
      .kind     (dec.kind),
      .byte_idx (dec.byte_idx),
      .wdata    (bus_wdata),
      .pin_in   (pin_in[CORE_PINS-1:0]),
      .rd_byte  (rd_core),
      .en_q     (en_all[CORE_PINS-1:0]),
      .dir_q    (dir_all[CORE_PINS-1:0]),
      .lvl_q    (lvl_all[CORE_PINS-1:0])
   );

   gdb_bank #(.NPIN(RES_PINS), .EN_CNT(RESUME_EN_CNT), .SYNC_STAGES(SYNC_STAGES)) u_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_res),
      .kind     (dec.kind),
      .byte_idx (dec.byte_idx),
      .wdata    (bus_wdata),
      .pin_in   (pin_in[NUM_PINS-1:RESUME_START]),
      .rd_byte  (rd_res),
      .en_q     (en_all[NUM_PINS-1:RESUME_START]),
      .dir_q    (dir_all[NUM_PINS-1:RESUME_START]),
      .lvl_q    (lvl_all[NUM_PINS-1:RESUME_START])
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= 8'h00;
      end else if (bus_rd && dec.hit) begin
         bus_rdata <= dec.bank ? rd_res : rd_core;
      end else begin
         bus_rdata <= 8'h00;
      end
   end

   assign pin_out = lvl_all;
   assign pin_oe  = en_all & ~dir_all;
endmodule

// File: rtl/gdb_checker.sv
module gdb_checker #(
   parameter int NUM_PINS     = 14,
   parameter int RESUME_START = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic [7:0]          bus_addr,
   input logic [7:0]          bus_wdata,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [7:0]          bus_rdata,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic [NUM_PINS-1:0] dir_all
);
   // R5: level write to an input pin leaves the driven value alone
   assert_lvl_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'h08 && dir_all[0]) |=> $stable(pin_out[0]));

   // R4: level write to an output pin appears one cycle later
   assert_lvl_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'h08 && !dir_all[0]) |=> (pin_out[0] == $past(bus_wdata[0])));

   // R3: setting a direction bit to input removes the output enable
   assert_dir_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'h04 && bus_wdata[0]) |=> !pin_oe[0]);

   // R2: the first resume pin lives at bit 0 of offset 0x28
   assert_resume_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'h28 && !dir_all[RESUME_START])
      |=> (pin_out[RESUME_START] == $past(bus_wdata[0])));

   // R7: no read strobe means zero read data in the next cycle
   assert_idle_rdata_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == 8'h00));

   // R8: offsets outside the register window read as zero
   assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[7:6] != 2'b00) |=> (bus_rdata == 8'h00));
endmodule

bind dual_bank_gpio gdb_checker #(.NUM_PINS(NUM_PINS), .RESUME_START(RESUME_START)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .dir_all   (dir_all)
);

// File: tb/sim_dual_bank_gpio.sv
module sim_dual_bank_gpio;
   localparam int N  = 14;
   localparam int RS = 10;
   localparam int CE = 7;
   localparam int RE = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic [N-1:0] pin_in = '0, pin_out, pin_oe;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dual_bank_gpio #(.NUM_PINS(N), .RESUME_START(RS), .CORE_EN_CNT(CE),
                    .RESUME_EN_CNT(RE)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

   // behavioural reference model
   bit m_en [N], m_dir [N], m_lvl [N], m_s1 [N], m_s2 [N];
   logic [7:0] m_rdata;

   function automatic int pin_of(input logic [7:0] a, input int b, output bit ok);
      int local_idx, cnt, base;
      ok = 1'b0;
      if (a[7:6] != 2'b00 || a[4:2] > 3'd2) return 0;
      base = a[5] ? RS : 0;
      cnt  = a[5] ? (N - RS) : RS;
      local_idx = int'(a[1:0]) * 8 + b;
      if (local_idx >= cnt) return 0;
      ok = 1'b1;
      return base + local_idx;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_en[i]  = (i < RS) ? (i < CE) : ((i - RS) < RE);
            m_dir[i] = 1'b1; m_lvl[i] = 1'b0; m_s1[i] = 1'b0; m_s2[i] = 1'b0;
         end
         m_rdata = 8'h00;
      end else begin
         logic [7:0] r;
         r = 8'h00;
         if (bus_rd) begin
            for (int b = 0; b < 8; b++) begin
               bit ok; int p;
               p = pin_of(bus_addr, b, ok);
               if (ok) begin
                  case (bus_addr[4:2])
                     3'd0: r[b] = m_en[p];
                     3'd1: r[b] = m_dir[p];
                     default: r[b] = m_dir[p] ? m_s2[p] : m_lvl[p];
                  endcase
               end
            end
         end
         if (bus_wr) begin
            for (int b = 0; b < 8; b++) begin
               bit ok; int p;
               p = pin_of(bus_addr, b, ok);
               if (ok) begin
                  case (bus_addr[4:2])
                     3'd0: m_en[p] = bus_wdata[b];
                     3'd1: m_dir[p] = bus_wdata[b];
                     default: if (!m_dir[p]) m_lvl[p] = bus_wdata[b];
                  endcase
               end
            end
         end
         for (int i = 0; i < N; i++) begin
            m_s2[i] = m_s1[i];
            m_s1[i] = pin_in[i];
         end
         m_rdata = r;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [N-1:0] eo, ee;
         for (int i = 0; i < N; i++) begin
            eo[i] = m_lvl[i];
            ee[i] = m_en[i] & ~m_dir[i];
         end
         check("R4 pin_out vs model", 32'(pin_out), 32'(eo));
         check("R3 pin_oe vs model", 32'(pin_oe), 32'(ee));
         check("R7 rdata vs model", 32'(bus_rdata), 32'(m_rdata));
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input string tag, input logic [7:0] exp);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      check(tag, 32'(bus_rdata), 32'(exp));
   endtask

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=<20000", cyc);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 pin_oe reset", 32'(pin_oe), 32'h0);
      check("R1 pin_out reset", 32'(pin_out), 32'h0);
      check("R1 rdata reset", 32'(bus_rdata), 32'h0);
      rd(8'h00, "R1 core enable", 8'h7F);
      rd(8'h01, "R1 core enable hi", 8'h00);
      rd(8'h20, "R1 resume enable", 8'h07);
      rd(8'h04, "R1 core dir", 8'hFF);
      rd(8'h05, "R8 core dir beyond count", 8'h03);
      rd(8'h24, "R8 resume dir beyond count", 8'h0F);
      wr(8'h01, 8'hFF);
      rd(8'h01, "R9 enable pins 8..9", 8'h03);
      wr(8'h08, 8'hFF);
      rd(8'h08, "R5 level of inputs reads pins", 8'h00);
      wr(8'h04, 8'hF0);
      check("R3 oe after dir write", 32'(pin_oe), 32'h000F);
      check("R5 ignored preset", 32'(pin_out), 32'h0);
      wr(8'h08, 8'h05);
      check("R4 level drive", 32'(pin_out), 32'h0005);
      @(negedge clk);
      pin_in = '1;
      rd(8'h08, "R6 read right after pin change", 8'h05);
      @(negedge clk);
      rd(8'h08, "R6 synced input", 8'hF5);
      wr(8'h24, 8'h00);
      wr(8'h20, 8'h0F);
      wr(8'h28, 8'h0A);
      check("R2 resume pin_out", 32'(pin_out), 32'h2805);
      check("R2 resume pin_oe", 32'(pin_oe), 32'h3C0F);
      rd(8'h28, "R2 resume level", 8'h0A);
      rd(8'h0C, "R8 unmapped 0x0C", 8'h00);
      rd(8'h02, "R8 byte beyond bank", 8'h00);
      rd(8'h21, "R8 resume byte beyond", 8'h00);
      rd(8'h40, "R8 outside window", 8'h00);
      wr(8'h0C, 8'hFF);
      wr(8'h48, 8'hFF);
      check("R8 unmapped write", 32'(pin_out), 32'h2805);
      wr(8'h00, 8'h7E);
      check("R3 disable pin0", 32'(pin_oe), 32'h3C0E);
      // R7 read and write in the same cycle returns the old value
      @(negedge clk);
      bus_addr = 8'h28; bus_wdata = 8'h05; bus_wr = 1'b1; bus_rd = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      check("R7 read before write", 32'(bus_rdata), 32'h0A);
      @(negedge clk);
      check("R7 idle rdata", 32'(bus_rdata), 32'h0);
      check("R4 resume level after write", 32'(pin_out), 32'h1405);
      pin_in = '0;
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule